// File: doc/BRIEF.md
# SHA-1 Message Schedule Window

This block sits between a message source and an SHA-1 round engine. It is loaded with one 512-bit message block as sixteen 32-bit words, written one at a time. It then hands the round engine the eighty schedule words in order, one word per accepted request. The first sixteen words are the loaded words, passed on unchanged. The remaining sixty-four words are produced on the fly from a sliding window of sixteen registers. Each newly derived word takes the slot of the word that was just retired, so storage never grows beyond sixteen words.

The load side has a word bus and a valid strobe. Words are taken only while the unit is filling. On the consumer side, `w_valid` shows that `w_word` holds the current schedule word, and `w_next` retires it. When the eightieth word is retired, the unit drops back to filling and pulses `blk_done` for one cycle. The next block may start loading in that same cycle. Message padding and the compression rounds are handled elsewhere.

Top module: `sha1_sched_window`

## Requirements
- R1: While `rst_n` is low at a clock edge, the unit enters the filling state. After that edge `w_valid` and `blk_done` are 0 and the next load goes to word position 0.
- R2: While filling, each cycle with `ld_valid` high stores `ld_word` as the next message word (positions 0 to 15 in arrival order). `w_valid` rises in the cycle after the sixteenth stored word.
- R3: While filling, a cycle with `ld_valid` low stores nothing. Gaps between load words are allowed, and `w_valid` stays low until sixteen words have been stored.
- R4: Schedule words 0 to 15 appear on `w_word` equal to the stored message words, in the order they were loaded.
- R5: Schedule word t, for t from 16 to 79, equals the XOR of words t-3, t-8, t-14 and t-16, rotated left by one bit.
- R6: While `w_valid` is high and `w_next` is low, `w_word` keeps its value and the schedule does not advance.
- R7: Exactly 80 words are issued per block. `w_valid` falls in the cycle after the 80th word is retired.
- R8: `blk_done` is high for exactly the one cycle after the cycle in which the 80th word is retired. At no other time is it high.
- R9: While `w_valid` is high, `ld_valid` and `ld_word` have no effect, including in the cycle that retires the 80th word. The issued words stay those of the current block.
- R10: `w_next` has no effect while `w_valid` is low.
- R11: A new block may be loaded starting in the cycle in which `blk_done` is high. Its first word goes to position 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_valid | input | 1 | Load strobe; word is taken while filling |
| ld_word | input | WORD_W | Message word to load |
| w_next | input | 1 | Retire the current schedule word |
| w_valid | output | 1 | `w_word` holds a schedule word |
| w_word | output | WORD_W | Current schedule word |
| blk_done | output | 1 | One-cycle pulse after the 80th word is retired |

## Verification
Two events can fall in the same cycle: the retirement of the last schedule word and a load strobe from a source that is already offering the next block. The bench drives `ld_valid` high with a marker word in the very cycle that retires word 79. It then starts the next block in the `blk_done` cycle. The marker must never appear as word 0 of the following block, and that block must be issued complete and in order. A second overlap is the in-place write: a slot is read as the oldest word and overwritten with the newly derived word in the same cycle. The bench judges this by comparing every issued word against a schedule computed independently from the loaded message, with random stalls on `w_next`.

// File: rtl/sha1_sched_pkg.sv
// Package: shared types and tap geometry for the SHA-1 schedule window.
// Assumes the window depth equals the largest tap lag (16).
package sha1_sched_pkg;

    // Operating state: collecting message words or issuing schedule words.
    typedef enum logic {
        MODE_FILL  = 1'b0,
        MODE_ISSUE = 1'b1
    } sched_mode_e;

    // Number of earlier words combined into one derived word.
    localparam int unsigned NUM_TAPS = 4;

    // Lag of each tap behind the word being derived; entry 0 is the oldest.
    localparam int unsigned TAP_LAG [NUM_TAPS] = '{16, 14, 8, 3};

endpackage

// File: rtl/sha1_sched_ctrl.sv
// Module: sequencing for the schedule window.
// Tracks fill position, the head (oldest) slot and the round index.
// Decides when and where the storage is written.
// Assumes WIN_DEPTH is a power of two, so the pointers wrap naturally.
module sha1_sched_ctrl
    import sha1_sched_pkg::*;
#(
    parameter int WIN_DEPTH = 16,
    parameter int ROUNDS    = 80,
    localparam int PW       = $clog2(WIN_DEPTH),
    localparam int RW       = $clog2(ROUNDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_valid,
    input  logic          w_next,
    output logic          wr_en,
    output logic          wr_from_load,
    output logic [PW-1:0] wr_addr,
    output logic [PW-1:0] head,
    output logic          issue,
    output logic          done
);

    localparam int GEN_LIMIT = ROUNDS - WIN_DEPTH;

    sched_mode_e   mode;
    logic [PW-1:0] fill_ptr;
    logic [PW-1:0] head_ptr;
    logic [RW-1:0] rnd;

    logic load_acc;
    logic take;
    logic last_fill;
    logic last_take;
    logic gen_due;

    // Decode the events of this cycle.
    always_comb begin
        load_acc  = (mode == MODE_FILL) && ld_valid;
        take      = (mode == MODE_ISSUE) && w_next;
        last_fill = (fill_ptr == PW'(WIN_DEPTH - 1));
        last_take = (rnd == RW'(ROUNDS - 1));
        gen_due   = (rnd < RW'(GEN_LIMIT));
    end

    // Mode register: fill until the window is full, issue until the last round.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode <= MODE_FILL;
        else if (load_acc && last_fill)
            mode <= MODE_ISSUE;
        else if (take && last_take)
            mode <= MODE_FILL;
    end

    // Fill pointer: next slot for an incoming message word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fill_ptr <= '0;
        else if (load_acc)
            fill_ptr <= fill_ptr + PW'(1);
    end

    // Head pointer: slot of the oldest word, which is the word being issued.
    always_ff @(posedge clk) begin
        if (!rst_n)
            head_ptr <= '0;
        else if (take)
            head_ptr <= last_take ? '0 : head_ptr + PW'(1);
    end

    // Round index of the word being issued.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rnd <= '0;
        else if (take)
            rnd <= last_take ? '0 : rnd + RW'(1);
    end

    // Completion pulse, one cycle after the final word is retired.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done <= 1'b0;
        else
            done <= take && last_take;
    end

    // Storage write control: loads while filling, derived words while issuing.
    always_comb begin
        wr_from_load = (mode == MODE_FILL);
        wr_en        = load_acc || (take && gen_due);
        wr_addr      = wr_from_load ? fill_ptr : head_ptr;
        head         = head_ptr;
        issue        = (mode == MODE_ISSUE);
    end

endmodule

// File: rtl/sha1_win_store.sv
// Module: circular window of message words with one write port and
// one read port per tap. Read addresses are the head plus a fixed offset.
// Assumes WIN_DEPTH is a power of two, so address arithmetic wraps.
module sha1_win_store
    import sha1_sched_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int WIN_DEPTH = 16,
    localparam int PW       = $clog2(WIN_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [PW-1:0]     head,
    output logic [WORD_W-1:0] tap_word [NUM_TAPS]
);

    logic [WORD_W-1:0] slot [WIN_DEPTH];

    // Slot registers: cleared by reset, one word written per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WIN_DEPTH; i++)
                slot[i] <= '0;
        end else if (wr_en) begin
            slot[wr_addr] <= wr_data;
        end
    end

    // One read port per tap, at a fixed distance from the oldest slot.
    for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
        localparam int OFS = WIN_DEPTH - int'(TAP_LAG[k]);
        logic [PW-1:0] rd_addr;
        // Tap address relative to the head.
        always_comb begin
            rd_addr     = head + PW'(OFS);
            tap_word[k] = slot[rd_addr];
        end
    end

endmodule

// File: rtl/sha1_expand.sv
// Module: combinational derivation of the next schedule word.
// Combines all tap words by XOR and rotates the result left by one.
// Assumes tap 0 is the oldest word; tap order has no effect on the XOR.
module sha1_expand
    import sha1_sched_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] tap_word [NUM_TAPS],
    output logic [WORD_W-1:0] new_word
);

    logic [WORD_W-1:0] mix;

    // XOR all taps together, then rotate left by one bit.
    always_comb begin
        mix = '0;
        for (int k = 0; k < NUM_TAPS; k++)
            mix = mix ^ tap_word[k];
        new_word = {mix[WORD_W-2:0], mix[WORD_W-1]};
    end

endmodule

// File: rtl/sha1_sched_window.sv
// Module: SHA-1 message schedule window (top).
// Loads sixteen words, then issues eighty schedule words on request.
// Derived words are produced in place within sixteen slots.
// Assumes WIN_DEPTH = 16 and ROUNDS = 80 for SHA-1 behaviour.
module sha1_sched_window
    import sha1_sched_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int WIN_DEPTH = 16,
    parameter int ROUNDS    = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [WORD_W-1:0] ld_word,
    input  logic              w_next,
    output logic              w_valid,
    output logic [WORD_W-1:0] w_word,
    output logic              blk_done
);

    localparam int PW = $clog2(WIN_DEPTH);

    logic              wr_en;
    logic              wr_from_load;
    logic [PW-1:0]     wr_addr;
    logic [PW-1:0]     head;
    logic              issue;
    logic              done;
    logic [WORD_W-1:0] tap_word [NUM_TAPS];
    logic [WORD_W-1:0] new_word;
    logic [WORD_W-1:0] wr_data;

    sha1_sched_ctrl #(
        .WIN_DEPTH (WIN_DEPTH),
        .ROUNDS    (ROUNDS)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .ld_valid     (ld_valid),
        .w_next       (w_next),
        .wr_en        (wr_en),
        .wr_from_load (wr_from_load),
        .wr_addr      (wr_addr),
        .head         (head),
        .issue        (issue),
        .done         (done)
    );

    sha1_win_store #(
        .WORD_W    (WORD_W),
        .WIN_DEPTH (WIN_DEPTH)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .head     (head),
        .tap_word (tap_word)
    );

    sha1_expand #(
        .WORD_W (WORD_W)
    ) u_expand (
        .tap_word (tap_word),
        .new_word (new_word)
    );

    // Write data: message word while filling, derived word while issuing.
    always_comb begin
        wr_data = wr_from_load ? ld_word : new_word;
    end

    // Outputs: the oldest slot is the word offered to the round engine.
    always_comb begin
        w_valid  = issue;
        w_word   = tap_word[0];
        blk_done = done;
    end

endmodule

// File: rtl/sha1_sched_window_chk.sv
// Checker: temporal properties of the schedule window, seen at its ports.
module sha1_sched_window_chk #(
    parameter int WORD_W    = 32,
    parameter int WIN_DEPTH = 16,
    parameter int ROUNDS    = 80
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ld_valid,
    input logic              w_next,
    input logic              w_valid,
    input logic [WORD_W-1:0] w_word,
    input logic              blk_done
);

    logic [7:0] loads_seen;
    logic [7:0] words_seen;

    // Count load strobes since the unit last issued.
    always_ff @(posedge clk) begin
        if (!rst_n)
            loads_seen <= '0;
        else if (w_valid)
            loads_seen <= '0;
        else if (ld_valid)
            loads_seen <= loads_seen + 8'd1;
    end

    // Count retired words within the current block.
    always_ff @(posedge clk) begin
        if (!rst_n)
            words_seen <= '0;
        else if (blk_done)
            words_seen <= '0;
        else if (w_valid && w_next)
            words_seen <= words_seen + 8'd1;
    end

    assert_issue_after_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(w_valid) |-> (loads_seen == 8'(WIN_DEPTH)));

    assert_idle_without_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!w_valid && !ld_valid) |=> !w_valid);

    assert_word_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (w_valid && !w_next) |=> (w_valid && $stable(w_word)));

    assert_issue_ends_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(w_valid) |-> blk_done);

    assert_done_after_all_words_R8: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |-> (words_seen == 8'(ROUNDS) && !w_valid));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |=> !blk_done);

endmodule

bind sha1_sched_window sha1_sched_window_chk #(
    .WORD_W    (WORD_W),
    .WIN_DEPTH (WIN_DEPTH),
    .ROUNDS    (ROUNDS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_valid (ld_valid),
    .w_next   (w_next),
    .w_valid  (w_valid),
    .w_word   (w_word),
    .blk_done (blk_done)
);

// File: tb/sha1_sched_window_test.sv
module sha1_sched_window_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_valid = 1'b0;
    logic [31:0] ld_word = '0;
    logic        w_next = 1'b0;
    logic        w_valid;
    logic [31:0] w_word;
    logic        blk_done;

    int vectors = 0;
    int fails = 0;

    // Reference model state
    bit          m_idle = 1'b1;
    bit          m_done = 1'b0;
    logic [31:0] m_q[$];
    logic [31:0] m_sched [80];
    int          m_idx = 0;

    always #2 clk = ~clk;

    sha1_sched_window uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_valid (ld_valid),
        .ld_word  (ld_word),
        .w_next   (w_next),
        .w_valid  (w_valid),
        .w_word   (w_word),
        .blk_done (blk_done)
    );

    task automatic build_sched();
        for (int t = 0; t < 16; t++) m_sched[t] = m_q[t];
        for (int t = 16; t < 80; t++) begin
            logic [31:0] x;
            x = m_sched[t-3] ^ m_sched[t-8] ^ m_sched[t-14] ^ m_sched[t-16];
            m_sched[t] = {x[30:0], x[31]};
        end
    endtask

    task automatic model_edge(input bit lv, input logic [31:0] lw, input bit nx, input bit rst);
        m_done = 1'b0;
        if (rst) begin
            m_idle = 1'b1; m_idx = 0; m_q.delete();
        end else if (m_idle) begin
            if (lv) begin
                m_q.push_back(lw);
                if (m_q.size() == 16) begin
                    build_sched(); m_q.delete(); m_idle = 1'b0; m_idx = 0;
                end
            end
        end else if (nx) begin
            m_idx++;
            if (m_idx == 80) begin
                m_idle = 1'b1; m_done = 1'b1; m_idx = 0;
            end
        end
    endtask

    task automatic check(input string tag);
        vectors++;
        if (w_valid !== !m_idle) begin
            fails++;
            $display("FAIL %s w_valid actual=%0b expected=%0b", tag, w_valid, !m_idle);
        end
        vectors++;
        if (blk_done !== m_done) begin
            fails++;
            $display("FAIL R8 (%s) blk_done actual=%0b expected=%0b", tag, blk_done, m_done);
        end
        if (!m_idle) begin
            vectors++;
            if (w_word !== m_sched[m_idx]) begin
                fails++;
                $display("FAIL %s word %0d actual=%h expected=%h",
                         (m_idx < 16) ? "R4" : "R5", m_idx, w_word, m_sched[m_idx]);
            end
        end
    endtask

    // One clock: drive at the falling edge, model at the rising edge, check at the next fall.
    task automatic cyc(input bit lv, input logic [31:0] lw, input bit nx, input string tag);
        ld_valid = lv; ld_word = lw; w_next = nx;
        @(posedge clk);
        model_edge(lv, lw, nx, !rst_n);
        @(negedge clk);
        check(tag);
    endtask

    // Load a block with optional gaps; kind selects the word pattern.
    task automatic load_block(input int kind, input bit gaps);
        for (int i = 0; i < 16; i++) begin
            logic [31:0] v;
            case (kind)
                0: v = $urandom;
                1: v = (i % 2 == 0) ? 32'hFFFF_FFFF : 32'h0000_0000;
                default: v = 32'h1 << (i * 2);
            endcase
            if (gaps && (i == 15)) begin
                for (int g = 0; g < 4; g++) cyc(1'b0, 32'hDEAD_0000 | g, g[0], "R3");
            end
            cyc(1'b1, v, 1'b0, "R2");
        end
    endtask

    // Drain the block with stalls; loads during issue are junk to be ignored.
    task automatic drain_block(input bit stalls);
        int taken = 0;
        while (taken < 80) begin
            bit nx;
            nx = stalls ? (($urandom % 4) != 0) : 1'b1;
            if (taken == 79) nx = 1'b1;
            cyc((taken % 5) == 1 || taken == 79, 32'hBAD0_0000 | taken,
                nx, nx ? "R7" : "R6");
            if (nx) taken++;
        end
    endtask

    initial begin
        @(negedge clk);
        cyc(1'b0, '0, 1'b0, "R1");
        cyc(1'b0, '0, 1'b0, "R1");
        rst_n = 1'b1;
        check("R1");
        // R10: requests while idle do nothing
        for (int i = 0; i < 3; i++) cyc(1'b0, '0, 1'b1, "R10");
        // R2, R3: gapped load, then stalled drain with ignored loads (R9)
        load_block(0, 1'b1);
        drain_block(1'b1);
        // R11: reload in the done cycle, alternating patterns
        load_block(1, 1'b0);
        drain_block(1'b0);
        load_block(2, 1'b0);
        drain_block(1'b1);
        // R9: trailing marker must not leak into the idle state
        for (int i = 0; i < 2; i++) cyc(1'b0, '0, 1'b1, "R9");
        load_block(0, 1'b0);
        drain_block(1'b1);
        // R1: reset mid-fill discards the partial block
        for (int i = 0; i < 5; i++) cyc(1'b1, 32'h5555_0000 | i, 1'b0, "R2");
        rst_n = 1'b0;
        cyc(1'b0, '0, 1'b0, "R1");
        rst_n = 1'b1;
        load_block(2, 1'b0);
        drain_block(1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule